// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a large internal register space through four 32-bit host registers. The host first loads a target address, and for a write also a data word. It then writes a command word that asks for a read or a write, and polls that command word until an acknowledge bit appears. Behind the host registers, the bridge drives one transfer on an internal register bus. That bus uses a request/ready handshake. The bridge keeps any returned word and raises acknowledge.

Acknowledge stays set until the host writes a clear command, so every access is a full handshake. The bridge takes a new command only after it has gone back to idle. Each access works on a private copy of the address and data, taken when the command is accepted. Later host writes to the address or data registers therefore cannot disturb a transfer that is already on the bus.

Top module: `regwin_bridge`

## Requirements
- R1: After reset all four host registers read 0 and `bus_req` is low.
- R2: Host register select is `host_addr[3:2]`: 0 is the command word, 1 the target address, 2 the fetched word (read-only, host writes are dropped), 3 the outgoing data word. The address and data registers read back exactly what was written.
- R3: Writing command value 0x2 (bit 1 = write) when idle starts one bus write with `bus_we`=1. The transfer uses the address and data register contents present at that moment.
- R4: Writing command value 0x1 (bit 0 = read) when idle starts one bus read with `bus_we`=0. Once the command reads back with bit 2 set, register 2 holds the word the target returned.
- R5: After a transfer completes, the command word reads 0x5 for a read or 0x6 for a write. It keeps that value, and register 2 stays unchanged, until the host writes a command with bits 1:0 both zero. The command word then reads 0 from the next cycle.
- R6: A command with bits 0 and 1 both set is dropped. No bus request follows and the command word keeps reading 0.
- R7: Command writes that arrive while a transfer is running or acknowledged are dropped. Address and data register writes during a transfer do not change the transfer that is already on the bus.
- R8: `bus_req` stays high, with `bus_addr`, `bus_we` and `bus_wdata` stable, until a cycle where `bus_ready` is high. The returned word is captured in that cycle, for any number of wait cycles.
- R9: A clear command written while a transfer is running makes the command word read 0 at once. The bus transfer still finishes, no acknowledge is raised, and the bridge returns to idle.
- R10: Bus addresses are word aligned: `bus_addr[1:0]` is 0 on every request, whatever the low bits of the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe, one register per cycle |
| host_addr | input | 4 | Host byte offset; bits 3:2 select the register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read-back of the selected register |
| bus_req | output | 1 | Internal bus request, held until ready |
| bus_we | output | 1 | 1 = write transfer, 0 = read transfer |
| bus_addr | output | 32 | Word-aligned internal address |
| bus_wdata | output | 32 | Internal write data |
| bus_ready | input | 1 | Target completes the transfer in this cycle |
| bus_rdata | input | 32 | Target read data, valid with `bus_ready` |

## Verification
A wrong controller state shows up at the command word right away. A stuck busy state keeps bits 1:0 set and never reaches 0x5 or 0x6. A lost clear shows as a command word that stays nonzero one cycle after the clear. A bad capture of the address or data appears as the wrong target word being modified, or the wrong word fetched, when the acknowledge is polled. A command accepted while busy appears as an extra bus transfer or a changed command code, within the same access.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } br_state_e;

    typedef enum logic [1:0] {
        SEL_CMD   = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_RDATA = 2'd2,
        SEL_WDATA = 2'd3
    } reg_sel_e;

    localparam int CMD_RD_BIT  = 0;
    localparam int CMD_WR_BIT  = 1;
    localparam int CMD_ACK_BIT = 2;
    localparam int CMD_VIEW_W  = 3;

    typedef struct packed {
        logic wr;
        logic rd;
    } cmd_req_t;

    function automatic logic cmd_is_clear(cmd_req_t c);
        return !c.rd && !c.wr;
    endfunction

    function automatic logic cmd_is_valid(cmd_req_t c);
        return c.rd ^ c.wr;
    endfunction

endpackage

// File: rtl/regwin_host_regs.sv
module regwin_host_regs
    import regwin_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  reg_sel_e              sel,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [CMD_VIEW_W-1:0] cmd_view,
    input  logic [DATA_W-1:0]     fetched,
    output logic [ADDR_W-1:0]     addr_q,
    output logic [DATA_W-1:0]     wdata_q,
    output logic                  cmd_wr,
    output cmd_req_t              cmd_req,
    output logic [DATA_W-1:0]     rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_ADDR)  addr_q  <= wdata[ADDR_W-1:0];
            if (sel == SEL_WDATA) wdata_q <= wdata;
        end
    end

    always_comb begin
        cmd_wr     = wr_en && (sel == SEL_CMD);
        cmd_req.rd = wdata[CMD_RD_BIT];
        cmd_req.wr = wdata[CMD_WR_BIT];
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CMD:   rdata[CMD_VIEW_W-1:0] = cmd_view;
            SEL_ADDR:  rdata[ADDR_W-1:0]     = addr_q;
            SEL_RDATA: rdata                 = fetched;
            SEL_WDATA: rdata                 = wdata_q;
        endcase
    end

endmodule

// File: rtl/regwin_cmd_ctrl.sv
module regwin_cmd_ctrl
    import regwin_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_wr,
    input  cmd_req_t              cmd_req,
    input  logic                  xfer_done,
    output logic                  start,
    output logic                  start_we,
    output logic                  ack,
    output logic [CMD_VIEW_W-1:0] cmd_view
);

    br_state_e state;
    cmd_req_t  op_q;
    logic      drop_q;
    logic      clr;

    always_comb begin
        clr      = cmd_wr && cmd_is_clear(cmd_req);
        start    = cmd_wr && (state == ST_IDLE) && cmd_is_valid(cmd_req);
        start_we = cmd_req.wr;
        ack      = (state == ST_DONE);
        cmd_view = '0;
        cmd_view[CMD_ACK_BIT] = ack;
        if (state != ST_IDLE && !drop_q) begin
            cmd_view[CMD_RD_BIT] = op_q.rd;
            cmd_view[CMD_WR_BIT] = op_q.wr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= '0;
            drop_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_BUSY;
                        op_q   <= cmd_req;
                        drop_q <= 1'b0;
                    end
                end
                ST_BUSY: begin
                    if (clr) drop_q <= 1'b1;
                    if (xfer_done) begin
                        if (drop_q || clr) begin
                            state  <= ST_IDLE;
                            op_q   <= '0;
                            drop_q <= 1'b0;
                        end else begin
                            state <= ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    if (clr) begin
                        state <= ST_IDLE;
                        op_q  <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !clr) |=> ack);

    // R6
    both_bits_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && cmd_wr && cmd_req.rd && cmd_req.wr) |=> (state == ST_IDLE));

    // R9
    drop_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && (drop_q || clr) && xfer_done) |=> !ack);

endmodule

// File: rtl/regwin_bus_master.sv
module regwin_bus_master #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_we,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] fetched_q,
    output logic              done
);

    localparam int ALIGN_W = $clog2(DATA_W / 8);

    assign done = bus_req && bus_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            fetched_q <= '0;
        end else if (start && !bus_req) begin
            bus_req   <= 1'b1;
            bus_we    <= start_we;
            bus_addr  <= {addr_in[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
            bus_wdata <= data_in;
        end else if (done) begin
            bus_req <= 1'b0;
            if (!bus_we) fetched_q <= bus_rdata;
        end
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R7
    no_start_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !bus_req);

endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int HOST_AW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               bus_req,
    output logic               bus_we,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ready,
    input  logic [DATA_W-1:0]  bus_rdata
);

    localparam int SEL_LSB = $clog2(DATA_W / 8);

    reg_sel_e                sel;
    logic [ADDR_W-1:0]       addr_q;
    logic [DATA_W-1:0]       wdata_q;
    logic [DATA_W-1:0]       fetched_q;
    logic                    cmd_wr;
    cmd_req_t                cmd_req;
    logic                    start, start_we, ack, done;
    logic [CMD_VIEW_W-1:0]   cmd_view;

    assign sel = reg_sel_e'(host_addr[SEL_LSB +: 2]);

    regwin_host_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(host_wr_en), .sel(sel), .wdata(host_wdata),
        .cmd_view(cmd_view), .fetched(fetched_q), .addr_q(addr_q), .wdata_q(wdata_q),
        .cmd_wr(cmd_wr), .cmd_req(cmd_req), .rdata(host_rdata)
    );

    regwin_cmd_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_req(cmd_req), .xfer_done(done),
        .start(start), .start_we(start_we), .ack(ack), .cmd_view(cmd_view)
    );

    regwin_bus_master #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst(rst), .start(start), .start_we(start_we), .addr_in(addr_q),
        .data_in(wdata_q), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .fetched_q(fetched_q), .done(done)
    );

    // R5
    fetched_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !(cmd_wr && cmd_is_clear(cmd_req))) |=> $stable(fetched_q));

    // R10
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_addr[SEL_LSB-1:0] == '0));

endmodule

// File: tb/tb_regwin_bridge.sv
module tb_regwin_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        bus_req, bus_we, bus_ready;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    int checks = 0;
    int fails  = 0;
    int xfers  = 0;
    int hold_bad = 0;
    int align_bad = 0;
    int lat = 0;
    logic [3:0]  wcnt = '0;
    logic [31:0] mem [16];
    logic        req_seen = 1'b0, rdy_seen = 1'b0;
    logic [31:0] addr_seen = '0;

    always #4 clk = ~clk;

    regwin_bridge dut (
        .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    // Target model: word memory, ready after lat wait cycles
    assign bus_ready = bus_req && (int'(wcnt) >= lat);
    assign bus_rdata = mem[bus_addr[5:2]];

    initial for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + i;

    always @(posedge clk) begin
        if (!bus_req || bus_ready) wcnt <= '0;
        else wcnt <= wcnt + 4'd1;
        if (bus_req && bus_ready) begin
            xfers <= xfers + 1;
            if (bus_we) mem[bus_addr[5:2]] <= bus_wdata;
        end
        if (req_seen && !rdy_seen && (!bus_req || bus_addr != addr_seen)) hold_bad <= hold_bad + 1;
        if (bus_req && bus_addr[1:0] != 2'b00) align_bad <= align_bad + 1;
        req_seen  <= bus_req;
        rdy_seen  <= bus_ready;
        addr_seen <= bus_addr;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [3:0] off, input logic [31:0] val);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = off; host_wdata = val;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic hread(input logic [3:0] off, output logic [31:0] val);
        host_addr = off;
        #1;
        val = host_rdata;
    endtask

    task automatic wait_ack();
        logic [31:0] v;
        for (int i = 0; i < 60; i++) begin
            hread(4'h0, v);
            if (v[2]) break;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        hread(4'h0, v); check("R1 cmd", v, 0);
        hread(4'h4, v); check("R1 addr", v, 0);
        hread(4'h8, v); check("R1 rdata", v, 0);
        hread(4'hC, v); check("R1 wdata", v, 0);
        check("R1 bus_req", {31'd0, bus_req}, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        hwrite(4'h4, 32'h1234_5678);
        hwrite(4'hC, 32'hDEAD_BEEF);
        hwrite(4'h8, 32'hFFFF_FFFF);
        hread(4'h4, v); check("R2 addr readback", v, 32'h1234_5678);
        hread(4'hC, v); check("R2 wdata readback", v, 32'hDEAD_BEEF);
        hread(4'h8, v); check("R2 rdata read-only", v, 0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        int x0;
        lat = 0;
        x0 = xfers;
        hwrite(4'hC, 32'h1111_2222);
        hwrite(4'h4, 32'h0000_0008);
        hwrite(4'h0, 32'h2);
        wait_ack();
        hread(4'h0, v); check("R5 write ack code", v, 32'h6);
        check("R3 mem word2", mem[2], 32'h1111_2222);
        check("R3 one transfer", xfers - x0, 1);
        hwrite(4'h0, 32'h0);
        hread(4'h0, v); check("R5 cleared", v, 0);
    endtask

    task automatic t_read();
        logic [31:0] v;
        lat = 3;
        hwrite(4'h4, 32'h0000_0014);
        hwrite(4'h0, 32'h1);
        wait_ack();
        hread(4'h0, v); check("R5 read ack code", v, 32'h5);
        hread(4'h8, v); check("R4 fetched word5", v, 32'hA000_0005);
        mem[5] = 32'h5555_0000;
        idle(6);
        hread(4'h0, v); check("R5 ack held", v, 32'h5);
        hread(4'h8, v); check("R5 fetched stable", v, 32'hA000_0005);
        hwrite(4'h0, 32'h0);
        hread(4'h0, v); check("R5 cleared after read", v, 0);
    endtask

    task automatic t_both();
        logic [31:0] v;
        int x0;
        lat = 0;
        x0 = xfers;
        hwrite(4'h0, 32'h3);
        idle(5);
        hread(4'h0, v); check("R6 cmd stays 0", v, 0);
        check("R6 no transfer", xfers - x0, 0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int x0;
        lat = 12;
        x0 = xfers;
        hwrite(4'hC, 32'hAAAA_0001);
        hwrite(4'h4, 32'h0000_0018);
        hwrite(4'h0, 32'h2);
        hwrite(4'h4, 32'h0000_001C);
        hwrite(4'hC, 32'hBBBB_0002);
        hwrite(4'h0, 32'h1);
        wait_ack();
        hread(4'h0, v); check("R7 code unchanged", v, 32'h6);
        check("R7 word6 old data", mem[6], 32'hAAAA_0001);
        check("R7 word7 untouched", mem[7], 32'hA000_0007);
        hwrite(4'h0, 32'h1);
        idle(3);
        hread(4'h0, v); check("R7 cmd in ack dropped", v, 32'h6);
        check("R7 single transfer", xfers - x0, 1);
        hwrite(4'h0, 32'h0);
    endtask

    task automatic t_align();
        logic [31:0] v;
        lat = 0;
        hwrite(4'h4, 32'h0000_0023);
        hread(4'h4, v); check("R10 addr reg keeps low bits", v, 32'h23);
        hwrite(4'h0, 32'h1);
        wait_ack();
        hread(4'h8, v); check("R10 aligned fetch word8", v, 32'hA000_0008);
        hwrite(4'h0, 32'h0);
        check("R10 no misaligned request", align_bad, 0);
    endtask

    task automatic t_drop();
        logic [31:0] v;
        int x0;
        lat = 8;
        x0 = xfers;
        hwrite(4'h4, 32'h0000_0004);
        hwrite(4'h0, 32'h1);
        hwrite(4'h0, 32'h0);
        hread(4'h0, v); check("R9 cmd 0 while running", v, 0);
        check("R9 request still up", {31'd0, bus_req}, 1);
        idle(15);
        hread(4'h0, v); check("R9 no ack", v, 0);
        check("R9 transfer finished", xfers - x0, 1);
        lat = 1;
        hwrite(4'h4, 32'h0000_0024);
        hwrite(4'h0, 32'h1);
        wait_ack();
        hread(4'h8, v); check("R9 later read works", v, 32'hA000_0009);
        hwrite(4'h0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_write();
        t_read();
        t_both();
        t_busy_ignore();
        t_align();
        t_drop();
        check("R8 request held until ready", hold_bad, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule